// File: doc/BRIEF.md
# Linked-Descriptor Output DMA Channel

This block is a single outbound DMA channel. Software places a chain of data descriptors in memory, each four 32-bit words long, points the channel at the first one and issues a start command. The channel reads the descriptor and sends every byte of its buffer window on a byte stream with a valid/ready handshake. It then writes the descriptor back to memory and follows the next pointer. It stops when it reaches a descriptor that carries the end-of-list flag.

Two pointers are held in registers: the saved descriptor pointer and the saved buffer pointer. Because each buffer resumes from the saved buffer pointer, software can restart a buffer that was partly drained. A continue command steps past the last finished descriptor and restarts the walk. A load-context command only moves the channel out of its reset state. Descriptors that carry the interrupt flag raise a raw interrupt bit. Software can mask that bit and clear it by writing a 1.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset the status register reads 0: state RESET is code 0 in bits [1:0], and the end-of-list flag in bit 8 is clear. The irq, out_valid and mem_req outputs are low.
- R2: Registers are selected by reg_addr[7:2]. The byte offsets are: command 0x00, status 0x04, saved descriptor pointer 0x08, saved buffer pointer 0x0C, interrupt mask 0x10, raw interrupt 0x14, acknowledge 0x18, masked interrupt 0x1C, stream command 0x20. The two pointers and the mask read back what was written.
- R3: Writing the command register with bit 0 set while the channel is idle does three things. It clears the end-of-list flag and sets the state to RUNNING (code 2). In the next cycle it also raises mem_req as a read of the saved descriptor pointer, with no further trigger.
- R4: Writing the stream command register with bit 0 set (load context) moves a RESET channel to STOPPED (code 1). It never makes the channel RUNNING and never issues a memory request.
- R5: Each descriptor is read as four words from the saved descriptor pointer: flags (bit 0 end-of-list, bit 1 interrupt), next pointer, buffer start and after address. The buffer then yields exactly (after address minus saved buffer pointer) bytes. The byte at address a is taken from the word at a with bits [1:0] cleared, lane a[1:0].
- R6: A byte is transferred only when out_valid and out_ready are both high. The byte holds steady while out_ready is low, and the saved buffer pointer rises by one for each transferred byte.
- R7: After every buffer, including the last one in the list, the four descriptor words are written back to the same four addresses.
- R8: After write-back of a descriptor with end-of-list set, the end-of-list flag is set, the state becomes STOPPED and the saved descriptor pointer stays on that descriptor. Otherwise the saved descriptor pointer takes the next pointer. The saved buffer pointer takes the new descriptor's buffer start, and the walk continues.
- R9: When a buffer finishes and its descriptor has the interrupt flag, raw interrupt bit 2 is set. irq is high exactly when raw AND mask is nonzero, and the masked register reads raw AND mask.
- R10: Writing a 1 to a bit of the acknowledge register clears that raw interrupt bit.
- R11: Writing the command register with bit 1 set (continue) while idle does two things. It moves the saved descriptor pointer to the last loaded descriptor's next pointer. It then walks from there, with the saved buffer pointer taken from the new descriptor's buffer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Output sink ready |
| irq | output | 1 | Interrupt request |

## Verification
The first walk covers a three-descriptor chain. It starts from a saved buffer pointer in the middle of the first buffer, so a design that restarts from the buffer start, or one that only reloads the pointer on later descriptors, shows up as extra bytes. The buffers start at unaligned addresses and the sink's ready line stalls every third cycle, which exposes byte-lane errors and loss of data under back-pressure. A continue command with the interrupt mask cleared separates the raw interrupt from the irq output. A final descriptor with an empty buffer shows that write-back and the end-of-list stop still happen when no byte is sent.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {CH_RESET = 2'd0, CH_STOPPED = 2'd1, CH_RUNNING = 2'd2} chan_st_e;
  typedef enum logic [2:0] {W_IDLE, W_FETCH, W_RDATA, W_SEND, W_STORE} walk_st_e;

  localparam int SEL_W = 6;
  localparam logic [SEL_W-1:0] SEL_CMD  = 6'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 6'd1;
  localparam logic [SEL_W-1:0] SEL_DPTR = 6'd2;
  localparam logic [SEL_W-1:0] SEL_BPTR = 6'd3;
  localparam logic [SEL_W-1:0] SEL_MASK = 6'd4;
  localparam logic [SEL_W-1:0] SEL_RAW  = 6'd5;
  localparam logic [SEL_W-1:0] SEL_ACK  = 6'd6;
  localparam logic [SEL_W-1:0] SEL_MSKD = 6'd7;
  localparam logic [SEL_W-1:0] SEL_SCMD = 6'd8;

  localparam int FLAG_EOL  = 0;
  localparam int FLAG_INTR = 1;
  localparam int STAT_EOL  = 8;

  function automatic logic [31:0] bytes_left(input logic [31:0] after_a, input logic [31:0] ptr);
    return after_a - ptr;
  endfunction

  function automatic logic [7:0] lane_pick(input logic [31:0] word, input logic [1:0] lane);
    return word[8*lane +: 8];
  endfunction
endpackage

// File: rtl/dmac_irq.sv
module dmac_irq #(
  parameter int IRQ_W   = 8,
  parameter int DATA_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             ack_we_i,
  input  logic             mask_we_i,
  input  logic [IRQ_W-1:0] wval_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] masked_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[DATA_BIT] = set_i;
    clr_vec = ack_we_i ? wval_i : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_o  <= '0;
      mask_o <= '0;
    end else begin
      raw_o <= (raw_o & ~clr_vec) | set_vec;
      if (mask_we_i) mask_o <= wval_i;
    end
  end

  assign masked_o = raw_o & mask_o;
  assign irq_o    = |masked_o;

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && !set_i) |=> ((raw_o & $past(wval_i)) == '0));
  p_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> raw_o[DATA_BIT]);
endmodule

// File: rtl/dmac_walker.sv
module dmac_walker
  import dmac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cont_i,
  input  logic         ldctx_i,
  input  logic         dptr_we_i,
  input  logic         bptr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         mem_ack_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         out_valid_o,
  output logic [7:0]   out_data_o,
  input  logic         out_ready_i,
  output logic [W-1:0] dptr_o,
  output logic [W-1:0] bptr_o,
  output chan_st_e     chst_o,
  output logic         eol_o,
  output logic         intr_set_o
);
  walk_st_e     st;
  logic [1:0]   widx;
  logic         fresh;
  logic [W-1:0] d_flags, d_next, d_buf, d_after;
  logic [7:0]   byte_q;

  logic left_zero, fetch_done, store_done, byte_take;
  assign left_zero  = (bytes_left(d_after, bptr_o) == '0);
  assign fetch_done = (st == W_FETCH) && mem_ack_i && (widx == 2'd3);
  assign store_done = (st == W_STORE) && mem_ack_i && (widx == 2'd3);
  assign byte_take  = (st == W_SEND) && out_ready_i;
  assign intr_set_o = (st == W_RDATA) && left_zero && d_flags[FLAG_INTR];

  assign mem_req_o   = (st == W_FETCH) || (st == W_STORE) || ((st == W_RDATA) && !left_zero);
  assign mem_we_o    = (st == W_STORE);
  assign mem_addr_o  = (st == W_RDATA) ? {bptr_o[W-1:2], 2'b00}
                                       : dptr_o + {{(W-4){1'b0}}, widx, 2'b00};
  assign out_valid_o = (st == W_SEND);
  assign out_data_o  = byte_q;

  always_comb begin
    case (widx)
      2'd0:    mem_wdata_o = d_flags;
      2'd1:    mem_wdata_o = d_next;
      2'd2:    mem_wdata_o = d_buf;
      default: mem_wdata_o = d_after;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE; widx <= '0; fresh <= 1'b0; eol_o <= 1'b0; chst_o <= CH_RESET;
      dptr_o <= '0; bptr_o <= '0; byte_q <= '0;
      d_flags <= '0; d_next <= '0; d_buf <= '0; d_after <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (dptr_we_i) dptr_o <= wdata_i;
          if (bptr_we_i) bptr_o <= wdata_i;
          if (start_i) begin
            eol_o <= 1'b0; chst_o <= CH_RUNNING; fresh <= 1'b0;
            st <= W_FETCH; widx <= '0;
          end else if (cont_i) begin
            dptr_o <= d_next; eol_o <= 1'b0; chst_o <= CH_RUNNING; fresh <= 1'b1;
            st <= W_FETCH; widx <= '0;
          end else if (ldctx_i && chst_o == CH_RESET) begin
            chst_o <= CH_STOPPED;
          end
        end
        W_FETCH: if (mem_ack_i) begin
          case (widx)
            2'd0:    d_flags <= mem_rdata_i;
            2'd1:    d_next  <= mem_rdata_i;
            2'd2:    d_buf   <= mem_rdata_i;
            default: d_after <= mem_rdata_i;
          endcase
          widx <= widx + 2'd1;
          if (fetch_done) begin
            if (fresh) bptr_o <= d_buf;
            fresh <= 1'b0;
            st <= W_RDATA;
          end
        end
        W_RDATA: begin
          if (left_zero) begin
            st <= W_STORE; widx <= '0;
          end else if (mem_ack_i) begin
            byte_q <= lane_pick(mem_rdata_i, bptr_o[1:0]);
            st <= W_SEND;
          end
        end
        W_SEND: if (byte_take) begin
          bptr_o <= bptr_o + 1'b1;
          st <= W_RDATA;
        end
        default: if (mem_ack_i) begin
          widx <= widx + 2'd1;
          if (store_done) begin
            if (d_flags[FLAG_EOL]) begin
              eol_o <= 1'b1; chst_o <= CH_STOPPED; st <= W_IDLE;
            end else begin
              dptr_o <= d_next; fresh <= 1'b1; st <= W_FETCH;
            end
          end
        end
      endcase
    end
  end

  p_fetch_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_IDLE && start_i) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(dptr_o)));
  p_ldctx_no_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_IDLE && ldctx_i && !start_i && !cont_i && chst_o != CH_RUNNING) |=> (chst_o != CH_RUNNING && !mem_req_o));
  p_hold_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  p_bptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i) |=> (bptr_o == $past(bptr_o) + 1'b1));
  p_eol_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eol_o) |-> $past(store_done));
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dmac_pkg::*;
#(
  parameter int W        = 32,
  parameter int IRQ_W    = 8,
  parameter int DATA_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [7:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic         out_valid,
  output logic [7:0]   out_data,
  input  logic         out_ready,
  output logic         irq
);
  logic [SEL_W-1:0] sel;
  assign sel = reg_addr[7:2];

  logic start_w, cont_w, ldctx_w, intr_set;
  logic [W-1:0] dptr, bptr;
  chan_st_e     chst;
  logic         eol;
  logic [IRQ_W-1:0] raw, mask, masked;

  assign start_w = reg_we && sel == SEL_CMD && reg_wdata[0];
  assign cont_w  = reg_we && sel == SEL_CMD && reg_wdata[1];
  assign ldctx_w = reg_we && sel == SEL_SCMD && reg_wdata[0];

  dmac_walker #(.W(W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .cont_i(cont_w), .ldctx_i(ldctx_w),
    .dptr_we_i(reg_we && sel == SEL_DPTR), .bptr_we_i(reg_we && sel == SEL_BPTR),
    .wdata_i(reg_wdata), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
    .dptr_o(dptr), .bptr_o(bptr), .chst_o(chst), .eol_o(eol), .intr_set_o(intr_set)
  );

  dmac_irq #(.IRQ_W(IRQ_W), .DATA_BIT(DATA_BIT)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(intr_set),
    .ack_we_i(reg_we && sel == SEL_ACK), .mask_we_i(reg_we && sel == SEL_MASK),
    .wval_i(reg_wdata[IRQ_W-1:0]), .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_STAT: begin
        reg_rdata[1:0]      = chst;
        reg_rdata[STAT_EOL] = eol;
      end
      SEL_DPTR: reg_rdata = dptr;
      SEL_BPTR: reg_rdata = bptr;
      SEL_MASK: reg_rdata[IRQ_W-1:0] = mask;
      SEL_RAW:  reg_rdata[IRQ_W-1:0] = raw;
      SEL_MSKD: reg_rdata[IRQ_W-1:0] = masked;
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[W-1:IRQ_W]};

  p_irq_vs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel == SEL_ACK && reg_wdata[IRQ_W-1:0] == '1 && !intr_set) |=> !irq);
endmodule

// File: tb/tb_dma_chain_chan.sv
module tb_dma_chain_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic out_valid, out_ready = 1'b0, irq;
  logic [7:0] out_data;

  int n_chk = 0, n_err = 0, cyc = 0, n_bytes = 0;
  logic [31:0] dmem [0:127];
  int wcnt [0:127];
  byte unsigned exp_q [$];

  always #4 clk = ~clk;

  dma_chain_chan dut (.*);

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    logic [31:0] b = {a[31:2], 2'b00};
    if (b >= 32'h100 && b < 32'h300) return dmem[(b - 32'h100) >> 2];
    return {fbyte(b + 3), fbyte(b + 2), fbyte(b + 1), fbyte(b)};
  endfunction

  initial begin
    for (int i = 0; i < 128; i++) begin dmem[i] = '0; wcnt[i] = 0; end
    forever begin
      @(posedge clk);
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          if (mem_addr >= 32'h100 && mem_addr < 32'h300) begin
            dmem[(mem_addr - 32'h100) >> 2] <= mem_wdata;
            wcnt[(mem_addr - 32'h100) >> 2] <= wcnt[(mem_addr - 32'h100) >> 2] + 1;
          end
        end else mem_rdata <= mem_read(mem_addr);
      end
    end
  end

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    out_ready <= ((cyc % 3) != 1);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // reference stream model: compared on every clock where a byte is handed over
  always @(negedge clk) if (rst_n && out_valid && out_ready) begin
    n_bytes++;
    if (exp_q.size() == 0) chk("R6 unexpected byte", {24'h0, out_data}, 32'hFFFF_FFFF);
    else chk("R5/R6 stream byte", {24'h0, out_data}, {24'h0, exp_q.pop_front()});
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_desc(input int base, input logic [31:0] fl, nx, bs, af);
    int i = (base - 32'h100) >> 2;
    dmem[i] = fl; dmem[i+1] = nx; dmem[i+2] = bs; dmem[i+3] = af;
  endtask

  task automatic expect_span(input logic [31:0] from, input logic [31:0] to);
    for (logic [31:0] a = from; a < to; a++) exp_q.push_back(fbyte(a));
  endtask

  task automatic wait_stop();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); rd(8'h04, s);
      if (s[1:0] == 2'd1) return;
    end
    chk("R8 channel never stopped", s, 32'h101);
  endtask

  function automatic int wsum(input int base);
    int i = (base - 32'h100) >> 2;
    return wcnt[i] + wcnt[i+1] + wcnt[i+2] + wcnt[i+3];
  endfunction

  initial begin
    logic [31:0] v;
    int nb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h04, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 out_valid", {31'h0, out_valid}, 0);
    chk("R1 mem_req", {31'h0, mem_req}, 0);

    wr(8'h20, 32'h1);
    rd(8'h04, v); chk("R4 load context -> STOPPED", v, 32'h1);
    chk("R4 no memory request", {31'h0, mem_req}, 0);
    repeat (4) @(negedge clk);
    rd(8'h04, v); chk("R4 still not running", v, 32'h1);

    put_desc(32'h100, 32'h2, 32'h120, 32'h1000, 32'h1009);
    put_desc(32'h120, 32'h0, 32'h140, 32'h1102, 32'h1107);
    put_desc(32'h140, 32'h3, 32'h160, 32'h1200, 32'h1204);
    put_desc(32'h160, 32'h3, 32'h180, 32'h1301, 32'h1303);
    put_desc(32'h180, 32'h1, 32'h0, 32'h1400, 32'h1400);

    wr(8'h08, 32'h100); wr(8'h0C, 32'h1003); wr(8'h10, 32'h4);
    rd(8'h08, v); chk("R2 descriptor pointer readback", v, 32'h100);
    rd(8'h0C, v); chk("R2 buffer pointer readback", v, 32'h1003);
    rd(8'h10, v); chk("R2 mask readback", v, 32'h4);

    expect_span(32'h1003, 32'h1009);
    expect_span(32'h1102, 32'h1107);
    expect_span(32'h1200, 32'h1204);
    wr(8'h00, 32'h1);
    rd(8'h04, v); chk("R3 status RUNNING", v, 32'h2);
    chk("R3 immediate fetch request", {31'h0, mem_req && !mem_we}, 1);
    chk("R3 fetch address", mem_addr, 32'h100);
    wait_stop();
    repeat (2) @(negedge clk);
    chk("R5 all bytes delivered", exp_q.size(), 0);
    chk("R5 byte count", n_bytes, 15);
    rd(8'h04, v); chk("R8 status STOPPED with eol", v, 32'h101);
    rd(8'h08, v); chk("R8 pointer stays on last descriptor", v, 32'h140);
    rd(8'h0C, v); chk("R6 buffer pointer at end", v, 32'h1204);
    chk("R7 writeback first", wsum(32'h100), 4);
    chk("R7 writeback middle", wsum(32'h120), 4);
    chk("R7 writeback last (eol)", wsum(32'h140), 4);
    chk("R7 writeback values kept", dmem[(32'h140 - 32'h100) >> 2], 32'h3);
    chk("R7 no touch past eol", wsum(32'h160), 0);
    rd(8'h14, v); chk("R9 raw bit 2", v, 32'h4);
    rd(8'h1C, v); chk("R9 masked", v, 32'h4);
    chk("R9 irq high", {31'h0, irq}, 1);

    wr(8'h18, 32'h4);
    rd(8'h14, v); chk("R10 raw cleared by ack", v, 32'h0);
    chk("R10 irq low after ack", {31'h0, irq}, 0);

    wr(8'h10, 32'h0);
    expect_span(32'h1301, 32'h1303);
    wr(8'h00, 32'h2);
    wait_stop();
    repeat (2) @(negedge clk);
    chk("R11 continue bytes", exp_q.size(), 0);
    rd(8'h08, v); chk("R11 pointer moved to next", v, 32'h160);
    rd(8'h0C, v); chk("R11 buffer from new start", v, 32'h1303);
    chk("R7 writeback after continue", wsum(32'h160), 4);
    rd(8'h14, v); chk("R9 raw set while masked", v, 32'h4);
    rd(8'h1C, v); chk("R9 masked reads zero", v, 32'h0);
    chk("R9 irq low when masked", {31'h0, irq}, 0);

    wr(8'h18, 32'h4);
    wr(8'h08, 32'h180); wr(8'h0C, 32'h1400);
    nb = n_bytes;
    wr(8'h00, 32'h1);
    wait_stop();
    repeat (2) @(negedge clk);
    chk("R5 empty buffer sends nothing", n_bytes, nb);
    chk("R7 empty buffer written back", wsum(32'h180), 4);
    rd(8'h14, v); chk("R9 no interrupt without flag", v, 32'h0);
    rd(8'h04, v); chk("R8 empty eol stop", v, 32'h101);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule